// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind the receive path of an Ethernet MAC and places each incoming frame into a ring of receive descriptors kept in on-chip storage. Every descriptor owns a fixed buffer slot, plus a length field and four status flags. Two of the flags set ownership and ring shape: EMPTY means the engine may fill the descriptor, and WRAP makes the descriptor the last one in the ring. The other two, LAST and ERR, report how the frame ended.

Software prepares the descriptors through a host write port. It starts the engine with a task-enable pulse. It reads back status, length, buffer pointer and payload words, and it returns consumed descriptors by marking them EMPTY again. If a frame starts while the current descriptor is still owned by software, the engine stalls, and frames that arrive during the stall are counted and discarded. Only a task-enable pulse lets the engine look at the ring again.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the current index is 0, the engine is stalled, the drop counter is 0, and every descriptor reads status 0 and length 0.
- R2: A host descriptor write sets EMPTY (status bit 0) and WRAP (status bit 1) from its inputs, clears LAST (bit 2) and ERR (bit 3), and clears the length.
- R3: The payload of an accepted frame goes into the descriptor's buffer slot, whose word pointer is index × ceil(MAXLEN/4). Byte k of the frame sits in word k/4, lane k mod 4, with the least significant byte first. A buffer word appears on buf_rdata one cycle after its address is presented.
- R4: When a frame ends, its descriptor gets a length equal to the number of bytes received, frame check sequence included. EMPTY is cleared, LAST is set and WRAP is left unchanged.
- R5: An error marker on any beat of an accepted frame sets ERR in that frame's descriptor.
- R6: After a descriptor with WRAP set is filled, the next index is 0. Otherwise the index steps up by one, and after index NDESC-1 it returns to 0.
- R7: A frame start that finds the current descriptor not EMPTY stalls the engine, discards the frame, adds one to the drop counter and leaves the descriptor unchanged.
- R8: While stalled, every frame start is discarded and counted, and the index does not move. Marking the descriptor EMPTY does not resume the engine by itself. A task-enable pulse does, and a descriptor that is still not EMPTY then stalls the engine again.
- R9: For a frame longer than MAXLEN bytes, only the first MAXLEN bytes are stored, the length reads MAXLEN and ERR is set. A frame of exactly MAXLEN bytes is stored whole, with no ERR.
- R10: Valid beats that arrive outside a frame without a start marker change no descriptor, no index and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Error reported on this beat |
| rx_data | input | 8 | Receive byte |
| task_en | input | 1 | Pulse that restarts a stalled engine |
| host_dwr | input | 1 | Descriptor write strobe |
| host_didx | input | IW | Descriptor to write |
| host_dempty | input | 1 | EMPTY value to write |
| host_dwrap | input | 1 | WRAP value to write |
| host_ridx | input | IW | Descriptor to read |
| rd_status | output | 4 | Status flags {ERR, LAST, WRAP, EMPTY} of host_ridx |
| rd_len | output | LW | Stored length of host_ridx |
| rd_ptr | output | AW | Buffer word pointer of host_ridx |
| host_baddr | input | AW | Buffer word address to read |
| buf_rdata | output | 32 | Buffer word, one cycle after host_baddr |
| cur_idx | output | IW | Descriptor the next frame will use |
| stalled | output | 1 | Engine waiting for task_en |
| drop_cnt | output | DROPW | Frames discarded, wraps modulo 2^DROPW |

## Verification
The hardest state to reach is a stall whose release depends on order. Software has to re-arm the blocking descriptor, a frame has to arrive before the task-enable pulse and be dropped, and only then may the pulse release the engine. Random rounds reach this by re-arming descriptors and pulsing task_en each with a certain probability, so stalls come and go at random points in the ring. A directed sequence then forces the order: all descriptors owned by software, a re-arm without the pulse, then the pulse. Other directed cases move the WRAP flag to the middle of the ring, clear it everywhere, and send frames of exactly and more than MAXLEN bytes.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int NDESC  = 8,
  parameter int MAXLEN = 1518,
  parameter int DROPW  = 16,
  localparam int IW    = $clog2(NDESC),
  localparam int LW    = $clog2(MAXLEN + 1),
  localparam int WPB   = (MAXLEN + 3) / 4,
  localparam int DEPTH = NDESC * WPB,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             rx_err,
  input  logic [7:0]       rx_data,
  input  logic             task_en,
  input  logic             host_dwr,
  input  logic [IW-1:0]    host_didx,
  input  logic             host_dempty,
  input  logic             host_dwrap,
  input  logic [IW-1:0]    host_ridx,
  output logic [3:0]       rd_status,
  output logic [LW-1:0]    rd_len,
  output logic [AW-1:0]    rd_ptr,
  input  logic [AW-1:0]    host_baddr,
  output logic [31:0]      buf_rdata,
  output logic [IW-1:0]    cur_idx,
  output logic             stalled,
  output logic [DROPW-1:0] drop_cnt
);
  localparam logic [LW-1:0] MAXL = LW'(MAXLEN);
  localparam logic [IW-1:0] LASTIDX = IW'(NDESC - 1);

  logic [NDESC-1:0] st_empty, st_wrap, st_last, st_err;
  logic [LW-1:0]    len_q [NDESC];
  logic [31:0]      mem [DEPTH];

  logic [IW-1:0]    cur_q;
  logic             run_q, infr_q, err_q;
  logic [LW-1:0]    cnt_q;
  logic [DROPW-1:0] drops_q;

  logic start, accept, drop, active, store, over, fin, fin_err;
  logic [LW-1:0] pos, new_len;
  logic [AW-1:0] waddr;

  assign start   = rx_valid & rx_sof & ~infr_q;
  assign accept  = start & run_q & st_empty[cur_q];
  assign drop    = start & ~accept;
  assign active  = accept | (infr_q & rx_valid);
  assign pos     = accept ? '0 : cnt_q;
  assign store   = active & (pos < MAXL);
  assign over    = active & ~(pos < MAXL);
  assign new_len = store ? pos + LW'(1) : pos;
  assign fin     = active & rx_eof;
  assign fin_err = (infr_q & err_q) | rx_err | over;
  assign waddr   = AW'(32'(cur_q) * WPB + 32'(pos >> 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      run_q    <= 1'b0;
      infr_q   <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      drops_q  <= '0;
      st_empty <= '0;
      st_wrap  <= '0;
      st_last  <= '0;
      st_err   <= '0;
      for (int i = 0; i < NDESC; i++) len_q[i] <= '0;
    end else begin
      if (task_en) run_q <= 1'b1;
      if (drop) begin
        run_q   <= 1'b0;
        drops_q <= drops_q + DROPW'(1);
      end
      if (host_dwr) begin
        st_empty[host_didx] <= host_dempty;
        st_wrap[host_didx]  <= host_dwrap;
        st_last[host_didx]  <= 1'b0;
        st_err[host_didx]   <= 1'b0;
        len_q[host_didx]    <= '0;
      end
      if (active) begin
        cnt_q  <= new_len;
        err_q  <= fin_err;
        infr_q <= ~rx_eof;
      end
      if (fin) begin
        st_empty[cur_q] <= 1'b0;
        st_last[cur_q]  <= 1'b1;
        st_err[cur_q]   <= fin_err;
        len_q[cur_q]    <= new_len;
        cur_q <= (st_wrap[cur_q] || cur_q == LASTIDX) ? '0 : cur_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[waddr][8*pos[1:0] +: 8] <= rx_data;
    buf_rdata <= mem[host_baddr];
  end

  assign rd_status = {st_err[host_ridx], st_last[host_ridx], st_wrap[host_ridx], st_empty[host_ridx]};
  assign rd_len    = len_q[host_ridx];
  assign rd_ptr    = AW'(32'(host_ridx) * WPB);
  assign cur_idx   = cur_q;
  assign stalled   = ~run_q;
  assign drop_cnt  = drops_q;
endmodule

module rx_ring_chk #(
  parameter int NDESC = 8,
  parameter int IW    = 3,
  parameter int DROPW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             task_en,
  input logic             start,
  input logic             accept,
  input logic             fin,
  input logic             fin_wrap,
  input logic [IW-1:0]    cur_idx,
  input logic             stalled,
  input logic [DROPW-1:0] drop_cnt
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    fin && fin_wrap |=> cur_idx == '0); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    fin && !fin_wrap && cur_idx != IW'(NDESC - 1) |=> cur_idx == $past(cur_idx) + IW'(1)); // R6
  AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
    start && !accept |=> drop_cnt == $past(drop_cnt) + DROPW'(1)); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stalled && !task_en |=> stalled); // R8
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stalled |=> $stable(cur_idx)); // R8
  AST_RESUME_BY_TASK: assert property (@(posedge clk) disable iff (rst)
    $fell(stalled) |-> $past(task_en)); // R8
endmodule

bind rx_ring_engine rx_ring_chk #(.NDESC(NDESC), .IW(IW), .DROPW(DROPW)) u_chk (
  .clk(clk), .rst(rst), .task_en(task_en), .start(start), .accept(accept),
  .fin(fin), .fin_wrap(st_wrap[cur_q]), .cur_idx(cur_idx), .stalled(stalled),
  .drop_cnt(drop_cnt)
);

// File: tb/tb_rx_ring_engine.sv
module tb_rx_ring_engine;
  localparam int ND = 8, MAXB = 1518, DW = 16;
  localparam int IW = $clog2(ND), LW = $clog2(MAXB + 1);
  localparam int WPB = (MAXB + 3) / 4, AW = $clog2(ND * WPB);

  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_data = 0;
  logic task_en = 0, host_dwr = 0, host_dempty = 0, host_dwrap = 0;
  logic [IW-1:0] host_didx = 0, host_ridx = 0;
  logic [AW-1:0] host_baddr = 0;
  logic [3:0] rd_status;
  logic [LW-1:0] rd_len;
  logic [AW-1:0] rd_ptr;
  logic [31:0] buf_rdata;
  logic [IW-1:0] cur_idx;
  logic stalled;
  logic [DW-1:0] drop_cnt;

  always #4 clk = ~clk;

  rx_ring_engine #(.NDESC(ND), .MAXLEN(MAXB), .DROPW(DW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] fbuf [2048];
  int m_cur = 0, m_drop = 0;
  bit m_stall = 1;
  bit m_empty [ND], m_wrap [ND], m_last [ND], m_err [ND];
  int m_len [ND];

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic int model_frame(int n, bit e);
    int idx;
    if (!m_stall && m_empty[m_cur]) begin
      idx = m_cur;
      m_len[idx] = (n > MAXB) ? MAXB : n;
      m_err[idx] = e || (n > MAXB);
      m_last[idx] = 1;
      m_empty[idx] = 0;
      m_cur = (m_wrap[idx] || idx == ND - 1) ? 0 : idx + 1;
      return idx;
    end
    m_stall = 1;
    m_drop++;
    return -1;
  endfunction

  task automatic hwrite(int i, bit e, bit w);
    @(negedge clk);
    host_dwr = 1; host_didx = IW'(i); host_dempty = e; host_dwrap = w;
    @(negedge clk);
    host_dwr = 0;
    m_empty[i] = e; m_wrap[i] = w; m_last[i] = 0; m_err[i] = 0; m_len[i] = 0;
  endtask

  task automatic kick();
    @(negedge clk); task_en = 1;
    @(negedge clk); task_en = 0;
    m_stall = 0;
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = 0; rx_eof = (i == n - 1); rx_data = 8'($urandom);
    end
    @(negedge clk);
    rx_valid = 0; rx_eof = 0;
  endtask

  task automatic send(int n, int errat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fbuf[i] = 8'($urandom);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_err = (i == errat); rx_data = fbuf[i];
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
  endtask

  task automatic check_desc(int i, string r);
    @(negedge clk); host_ridx = IW'(i); #1;
    chk({r, " status"}, 32'(rd_status), {28'd0, m_err[i], m_last[i], m_wrap[i], m_empty[i]});
    chk({r, " length"}, 32'(rd_len), 32'(m_len[i]));
  endtask

  task automatic check_data(int i, int n);
    int nw;
    logic [31:0] e, mask;
    nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk); host_baddr = AW'(i * WPB + w);
      @(negedge clk);
      e = 0; mask = 0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < n) begin
          e[8*b +: 8] = fbuf[w * 4 + b];
          mask[8*b +: 8] = 8'hff;
        end
      if (w == 0 || w == nw - 1 || (buf_rdata & mask) !== e)
        chk("R3 payload word", buf_rdata & mask, e);
    end
  endtask

  task automatic frame_and_check(int n, int errat, string r);
    int idx;
    send(n, errat);
    idx = model_frame(n, errat >= 0 && errat < n);
    chk({r, " index"}, 32'(cur_idx), 32'(m_cur));
    chk({r, " stalled"}, 32'(stalled), 32'(m_stall));
    chk({r, " drops"}, 32'(drop_cnt), 32'(m_drop));
    if (idx >= 0) begin
      check_desc(idx, r);
      check_data(idx, m_len[idx]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_empty[i] = 0; m_wrap[i] = 0; m_last[i] = 0; m_err[i] = 0; m_len[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 index", 32'(cur_idx), 0);
    chk("R1 stalled", 32'(stalled), 1);
    chk("R1 drops", 32'(drop_cnt), 0);
    for (int i = 0; i < ND; i++) check_desc(i, "R1");

    // R2 host write of every descriptor, WRAP on the last one; the pointer follows R3
    for (int i = 0; i < ND; i++) hwrite(i, 1, i == ND - 1);
    for (int i = 0; i < ND; i++) begin
      check_desc(i, "R2");
      chk("R3 pointer", 32'(rd_ptr), 32'(i * WPB));
    end
    // R7 frame before any task_en is dropped
    frame_and_check(10, -1, "R7");
    kick();
    // R10 stray beats without a start marker
    stray(5);
    chk("R10 index", 32'(cur_idx), 32'(m_cur));
    chk("R10 drops", 32'(drop_cnt), 32'(m_drop));
    check_desc(0, "R10");
    frame_and_check(1, -1, "R4 single byte");
    frame_and_check(MAXB, -1, "R9 exact max");
    frame_and_check(1600, -1, "R9 truncated");
    frame_and_check(20, 7, "R5 error");

    // random rounds: re-arm, restart, stray beats, frames with optional errors
    for (int it = 0; it < 60; it++) begin
      if ($urandom % 3 == 0)
        for (int i = 0; i < ND; i++) if (!m_empty[i]) hwrite(i, 1, m_wrap[i]);
      if ($urandom % 2 == 0) kick();
      if ($urandom % 4 == 0) stray(1 + $urandom % 3);
      frame_and_check(1 + $urandom % 64, ($urandom % 6 == 0) ? int'($urandom % 8) : -1, "R4/R5/R6 random");
    end

    // R8 directed: all owned by software, re-arm without task_en, then task_en
    for (int i = 0; i < ND; i++) hwrite(i, 0, i == ND - 1);
    kick();
    frame_and_check(12, -1, "R8 stall");
    hwrite(m_cur, 1, m_wrap[m_cur]);
    frame_and_check(12, -1, "R8 rearm only");
    kick();
    frame_and_check(12, -1, "R8 resumed");
    // R6 WRAP only on index 2
    for (int i = 0; i < ND; i++) hwrite(i, 1, i == 2);
    kick();
    for (int k = 0; k < 10; k++) begin
      frame_and_check(8, -1, "R6 short ring");
      if (m_stall) kick();
      for (int i = 0; i < ND; i++) if (!m_empty[i]) hwrite(i, 1, m_wrap[i]);
    end
    // R6 no WRAP anywhere: index NDESC-1 returns to 0
    for (int i = 0; i < ND; i++) hwrite(i, 1, 0);
    for (int k = 0; k < ND + 2; k++) begin
      frame_and_check(6, -1, "R6 no wrap");
      hwrite((m_cur + ND - 1) % ND, 1, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule